// File: doc/BRIEF.md
# Prioritized Interrupt Chain Controller

This block collects interrupt events from one serial controller channel and turns them into a single active-low request. The events are grouped into a fixed number of interrupt types, and each type has several sources. A source only raises its type's pending flag on a rising edge of its status line, and only while that source is armed. The types form a priority chain with type 0 at the top. Each type's position in the chain decides whether it may request service. It also decides whether the chain enable passes on to lower types and to any devices further down an external chain.

When the host runs an acknowledge cycle, the highest type that is currently requesting is taken into service. Its in-service flag is set and its pending flag is cleared. In the cycle after the acknowledge the block returns a vector built from a base value. Software can choose to have the winning type number placed in the low bits of that vector. Software ends service with a command that clears the highest in-service flag. It clears one pending flag with a second command. A master enable gates every request.

Top module: `irq_chain_ctrl`

## Requirements
- R1: A type's pending flag (`pend`) is set in the cycle after a 0-to-1 change of one of its status inputs, provided that source's arm bit is 1. A status line that stays high, falls, or belongs to an unarmed source sets nothing.
- R2: A command with code 4'h1 clears the pending flag of the type given in `cmd_type`. Any code other than 4'h1 and 4'h2 has no effect.
- R3: `irq_n` is low exactly when `chain_ein` is 1, the master enable is 1, and some type has pending and enable set with no in-service flag at that type or any higher type. Type 0 is the highest type.
- R4: An `ack` pulse while `irq_n` is low picks the highest-priority requesting type. It sets that type's in-service flag and clears that type's pending flag.
- R5: One cycle after an accepted `ack`, `vec_valid` is high for one cycle. If status-in-vector is enabled, `vec_out` holds `vec_base` with its low clog2(NT) bits replaced by the type number. Otherwise it holds `vec_base` unchanged. An `ack` with no request gives no `vec_valid`.
- R6: While `chain_ein` is 0, `irq_n` stays high and `chain_eout` stays low, and `ack` changes no state.
- R7: `chain_eout` is high only when `chain_ein` is high, no type is in service, and no type has pending, enable and master enable all set.
- R8: A command with code 4'h2 clears only the in-service flag of the highest-priority type that has one set.
- R9: When a new armed edge arrives in the same cycle as a clear of that type's pending flag, the pending flag stays set. The clear can come from a command or from an acknowledge.
- R10: After reset all pending, in-service, arm and enable bits are 0, `irq_n` is high, `vec_valid` is low, and `chain_eout` follows `chain_ein`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_stat | input | NT*NS | Source status lines, type t source s at bit t*NS+s |
| arm_we | input | 1 | Write arm bits of one type |
| arm_type | input | TW | Type whose arm bits are written |
| arm_bits | input | NS | New arm bits |
| cfg_we | input | 1 | Write enable bits, master enable and vector mode |
| cfg_ie | input | NT | Per-type enable bits |
| cfg_mie | input | 1 | Master enable |
| cfg_vis | input | 1 | Place type number in vector low bits |
| cmd_we | input | 1 | Command strobe |
| cmd_code | input | 4 | 4'h1 clear pending, 4'h2 clear highest in-service |
| cmd_type | input | TW | Type for the clear-pending command |
| vec_base | input | VEC_W | Base vector value |
| chain_ein | input | 1 | Chain enable from higher-priority devices |
| ack | input | 1 | Acknowledge strobe, one cycle |
| irq_n | output | 1 | Active-low interrupt request |
| chain_eout | output | 1 | Chain enable to lower-priority devices |
| vec_out | output | VEC_W | Vector returned for the last accepted acknowledge |
| vec_valid | output | 1 | Vector valid pulse |
| pend | output | NT | Pending flags per type |
| insvc | output | NT | In-service flags per type |

## Verification
Two things can land on the same pending flag in the same cycle: a fresh armed edge, and a clear of that flag. The clear comes either from the clear command or from an acknowledge that picks that type. The bench first makes a type pending. It then raises that type's status line again in the exact cycle that carries the clear command, and later in the exact cycle that carries the acknowledge. It judges the result by reading `pend` afterwards, which must still show the type, while `insvc` must show the acknowledged type in service.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef enum logic [3:0] {
        CMD_NOP     = 4'h0,
        CMD_CLR_IP  = 4'h1,
        CMD_RST_IUS = 4'h2
    } chain_cmd_e;

    typedef struct packed {
        logic mie;
        logic vis;
    } chain_ctl_t;

    // index of the lowest set bit (highest priority); 0 when none set
    function automatic logic [7:0] first_set_idx(input logic [31:0] v);
        logic [7:0] idx;
        idx = 8'd0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) idx = 8'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
    parameter int NT = 6,
    parameter int NS = 4,
    parameter int TW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NT*NS-1:0] src_stat,
    input  logic             arm_we,
    input  logic [TW-1:0]    arm_type,
    input  logic [NS-1:0]    arm_bits,
    output logic [NT-1:0]    type_evt
);
    logic [NT*NS-1:0] stat_q;
    logic [NT*NS-1:0] arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            arm_q  <= '0;
        end else begin
            stat_q <= src_stat;
            for (int i = 0; i < NT; i++) begin
                if (arm_we && arm_type == TW'(i))
                    arm_q[i*NS +: NS] <= arm_bits;
            end
        end
    end

    for (genvar g = 0; g < NT; g++) begin : g_type
        assign type_evt[g] = |(src_stat[g*NS +: NS] & ~stat_q[g*NS +: NS]
                              & arm_q[g*NS +: NS]);
    end
endmodule

// File: rtl/irq_type_cell.sv
module irq_type_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ip,
    input  logic ie,
    input  logic mie,
    input  logic grant_in,
    input  logic ack,
    input  logic rst_ius,
    output logic req,
    output logic grant_out,
    output logic ip,
    output logic ius
);
    logic active;

    assign active    = ip & ie & mie;
    assign req       = active & grant_in & ~ius;
    assign grant_out = grant_in & ~ius & ~active;

    always_ff @(posedge clk) begin
        if (rst) begin
            ip  <= 1'b0;
            ius <= 1'b0;
        end else begin
            if (set_ev)
                ip <= 1'b1;
            else if (clr_ip || (ack && req))
                ip <= 1'b0;

            if (ack && req)
                ius <= 1'b1;
            else if (rst_ius)
                ius <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
    import irq_chain_pkg::*;
#(
    parameter int NT    = 6,
    parameter int TW    = 3,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  logic [NT-1:0]    req,
    input  logic             vis,
    input  logic [VEC_W-1:0] base,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);
    logic [7:0]       idx;
    logic [VEC_W-1:0] vec_d;
    logic             take;

    assign idx   = first_set_idx(32'(req));
    assign vec_d = vis ? {base[VEC_W-1:TW], idx[TW-1:0]} : base;
    assign take  = ack & (|req);

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= take;
            if (take) vec_out <= vec_d;
        end
    end
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
    import irq_chain_pkg::*;
#(
    parameter int NT    = 6,
    parameter int NS    = 4,
    parameter int VEC_W = 8,
    localparam int TW   = $clog2(NT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NT*NS-1:0] src_stat,
    input  logic             arm_we,
    input  logic [TW-1:0]    arm_type,
    input  logic [NS-1:0]    arm_bits,
    input  logic             cfg_we,
    input  logic [NT-1:0]    cfg_ie,
    input  logic             cfg_mie,
    input  logic             cfg_vis,
    input  logic             cmd_we,
    input  logic [3:0]       cmd_code,
    input  logic [TW-1:0]    cmd_type,
    input  logic [VEC_W-1:0] vec_base,
    input  logic             chain_ein,
    input  logic             ack,
    output logic             irq_n,
    output logic             chain_eout,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    output logic [NT-1:0]    pend,
    output logic [NT-1:0]    insvc
);
    chain_ctl_t    ctl_q;
    logic [NT-1:0] ie_q;
    logic [NT-1:0] type_evt;
    logic [NT-1:0] clr_vec;
    logic [NT-1:0] req;
    logic [NT:0]   grant_c;
    logic [NT-1:0] rst_c;
    chain_cmd_e    cmd_e;
    logic          rst_go;
    logic          mie_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ie_q  <= '0;
        end else if (cfg_we) begin
            ctl_q.mie <= cfg_mie;
            ctl_q.vis <= cfg_vis;
            ie_q      <= cfg_ie;
        end
    end

    assign mie_en = ctl_q.mie;
    assign cmd_e  = chain_cmd_e'(cmd_code);
    assign rst_go = cmd_we && (cmd_e == CMD_RST_IUS);

    irq_src_edge #(.NT(NT), .NS(NS), .TW(TW)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .src_stat (src_stat),
        .arm_we   (arm_we),
        .arm_type (arm_type),
        .arm_bits (arm_bits),
        .type_evt (type_evt)
    );

    assign grant_c[0] = chain_ein;
    assign rst_c[0]   = rst_go;

    for (genvar g = 0; g < NT; g++) begin : g_cell
        assign clr_vec[g] = cmd_we && (cmd_e == CMD_CLR_IP) && (cmd_type == TW'(g));

        if (g < NT - 1) begin : g_rst_link
            assign rst_c[g+1] = rst_c[g] & ~insvc[g];
        end

        irq_type_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .set_ev    (type_evt[g]),
            .clr_ip    (clr_vec[g]),
            .ie        (ie_q[g]),
            .mie       (mie_en),
            .grant_in  (grant_c[g]),
            .ack       (ack),
            .rst_ius   (rst_c[g]),
            .req       (req[g]),
            .grant_out (grant_c[g+1]),
            .ip        (pend[g]),
            .ius       (insvc[g])
        );
    end

    assign chain_eout = grant_c[NT];
    assign irq_n      = ~(|req);

    irq_vec_gen #(.NT(NT), .TW(TW), .VEC_W(VEC_W)) u_vec (
        .clk       (clk),
        .rst       (rst),
        .ack       (ack),
        .req       (req),
        .vis       (ctl_q.vis),
        .base      (vec_base),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
    parameter int NT = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          chain_ein,
    input logic          chain_eout,
    input logic          irq_n,
    input logic          ack,
    input logic          vec_valid,
    input logic          mie,
    input logic          cmd_we,
    input logic [3:0]    cmd_code,
    input logic [NT-1:0] insvc
);
    assert_chain_block_R6: assert property (@(posedge clk) disable iff (rst)
        !chain_ein |-> (irq_n && !chain_eout));

    assert_eout_held_R7: assert property (@(posedge clk) disable iff (rst)
        (|insvc) |-> !chain_eout);

    assert_master_gate_R3: assert property (@(posedge clk) disable iff (rst)
        !mie |-> irq_n);

    assert_vec_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_n) |=> vec_valid);

    assert_no_vec_R5: assert property (@(posedge clk) disable iff (rst)
        !(ack && !irq_n) |=> !vec_valid);

    assert_service_add_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_n && !(cmd_we && cmd_code == 4'h2))
        |=> ($countones(insvc) == $past($countones(insvc)) + 1));
endmodule

bind irq_chain_ctrl irq_chain_chk #(.NT(NT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chain_ein  (chain_ein),
    .chain_eout (chain_eout),
    .irq_n      (irq_n),
    .ack        (ack),
    .vec_valid  (vec_valid),
    .mie        (mie_en),
    .cmd_we     (cmd_we),
    .cmd_code   (cmd_code),
    .insvc      (insvc)
);

// File: tb/tb_irq_chain_ctrl.sv
`timescale 1ns/1ps
module tb_irq_chain_ctrl;
    localparam int NT = 6;
    localparam int NS = 4;
    localparam int VEC_W = 8;
    localparam int TW = $clog2(NT);

    logic             clk = 1'b0;
    logic             rst;
    logic [NT*NS-1:0] src_stat;
    logic             arm_we;
    logic [TW-1:0]    arm_type;
    logic [NS-1:0]    arm_bits;
    logic             cfg_we;
    logic [NT-1:0]    cfg_ie;
    logic             cfg_mie;
    logic             cfg_vis;
    logic             cmd_we;
    logic [3:0]       cmd_code;
    logic [TW-1:0]    cmd_type;
    logic [VEC_W-1:0] vec_base;
    logic             chain_ein;
    logic             ack;
    logic             irq_n;
    logic             chain_eout;
    logic [VEC_W-1:0] vec_out;
    logic             vec_valid;
    logic [NT-1:0]    pend;
    logic [NT-1:0]    insvc;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    irq_chain_ctrl #(.NT(NT), .NS(NS), .VEC_W(VEC_W)) dut (
        .clk(clk), .rst(rst), .src_stat(src_stat), .arm_we(arm_we),
        .arm_type(arm_type), .arm_bits(arm_bits), .cfg_we(cfg_we),
        .cfg_ie(cfg_ie), .cfg_mie(cfg_mie), .cfg_vis(cfg_vis),
        .cmd_we(cmd_we), .cmd_code(cmd_code), .cmd_type(cmd_type),
        .vec_base(vec_base), .chain_ein(chain_ein), .ack(ack),
        .irq_n(irq_n), .chain_eout(chain_eout), .vec_out(vec_out),
        .vec_valid(vec_valid), .pend(pend), .insvc(insvc)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_arm(input int t, input logic [NS-1:0] bits);
        arm_we = 1'b1; arm_type = TW'(t); arm_bits = bits;
        tick();
        arm_we = 1'b0;
    endtask

    task automatic set_cfg(input logic [NT-1:0] ie, input logic mie, input logic vis);
        cfg_we = 1'b1; cfg_ie = ie; cfg_mie = mie; cfg_vis = vis;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic do_cmd(input logic [3:0] code, input int t);
        cmd_we = 1'b1; cmd_code = code; cmd_type = TW'(t);
        tick();
        cmd_we = 1'b0;
    endtask

    task automatic make_pending(input int t);
        src_stat[t*NS] = 1'b1;
        tick();
        src_stat[t*NS] = 1'b0;
        tick();
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    function automatic logic [VEC_W-1:0] exp_vec(input int t);
        return (vec_base & ~VEC_W'((1 << TW) - 1)) | VEC_W'(t);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_stat = '0; arm_we = 1'b0; arm_type = '0; arm_bits = '0;
        cfg_we = 1'b0; cfg_ie = '0; cfg_mie = 1'b0; cfg_vis = 1'b0;
        cmd_we = 1'b0; cmd_code = 4'h0; cmd_type = '0; vec_base = 8'hA8;
        chain_ein = 1'b1; ack = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();

        // R10 reset state
        chk("R10 irq_n", 32'(irq_n), 32'd1);
        chk("R10 pend", 32'(pend), 32'd0);
        chk("R10 insvc", 32'(insvc), 32'd0);
        chk("R10 vec_valid", 32'(vec_valid), 32'd0);
        chk("R10 eout", 32'(chain_eout), 32'd1);
        chain_ein = 1'b0; #1;
        chk("R10 eout follows ein", 32'(chain_eout), 32'd0);
        chain_ein = 1'b1;

        // R1 and R2 sweep over every source
        set_cfg('1, 1'b0, 1'b1);
        for (int t = 0; t < NT; t++) begin
            for (int s = 0; s < NS; s++) begin
                int other;
                other = t*NS + ((s + 1) % NS);
                set_arm(t, NS'(1 << s));
                src_stat[other] = 1'b1; tick();
                chk("R1 unarmed edge", 32'(pend), 32'd0);
                src_stat[other] = 1'b0; tick();
                src_stat[t*NS+s] = 1'b1; tick();
                chk("R1 armed edge", 32'(pend), 32'(1 << t));
                do_cmd(4'h5, t);
                chk("R2 other code", 32'(pend), 32'(1 << t));
                do_cmd(4'h1, (t + 1) % NT);
                chk("R2 other type", 32'(pend), 32'(1 << t));
                do_cmd(4'h1, t);
                chk("R2 clear", 32'(pend), 32'd0);
                tick();
                chk("R1 held level", 32'(pend), 32'd0);
                src_stat[t*NS+s] = 1'b0; tick();
                chk("R1 falling", 32'(pend), 32'd0);
                set_arm(t, '0);
            end
        end

        // R3 R4 R5 R7 R8 priority sweep over all type pairs
        for (int t = 0; t < NT; t++) set_arm(t, '1);
        set_cfg('1, 1'b1, 1'b1);
        for (int a = 0; a < NT; a++) begin
            for (int b = 0; b < NT; b++) begin
                int hi, lo;
                hi = (a < b) ? a : b;
                lo = (a < b) ? b : a;
                make_pending(a);
                make_pending(b);
                chk("R3 request", 32'(irq_n), 32'd0);
                chk("R7 eout active req", 32'(chain_eout), 32'd0);
                do_ack();
                chk("R5 vec_valid", 32'(vec_valid), 32'd1);
                chk("R5 vector type", 32'(vec_out), 32'(exp_vec(hi)));
                chk("R4 insvc", 32'(insvc), 32'(1 << hi));
                chk("R4 pend left", 32'(pend), 32'((1 << lo) & ~(1 << hi)));
                chk("R7 eout in service", 32'(chain_eout), 32'd0);
                if (a != b) begin
                    chk("R3 lower blocked", 32'(irq_n), 32'd1);
                    do_cmd(4'h2, 0);
                    chk("R5 pulse one cycle", 32'(vec_valid), 32'd0);
                    chk("R8 cleared", 32'(insvc), 32'd0);
                    chk("R3 lower released", 32'(irq_n), 32'd0);
                    do_ack();
                    chk("R5 vector lower", 32'(vec_out), 32'(exp_vec(lo)));
                    chk("R4 insvc lower", 32'(insvc), 32'(1 << lo));
                end
                do_cmd(4'h2, 0);
                chk("R8 all clear", 32'(insvc), 32'd0);
                chk("R4 pend clear", 32'(pend), 32'd0);
            end
        end

        // R3 R8 nesting
        make_pending(3);
        do_ack();
        make_pending(1);
        chk("R3 higher over service", 32'(irq_n), 32'd0);
        make_pending(5);
        do_ack();
        chk("R5 nested vector", 32'(vec_out), 32'(exp_vec(1)));
        chk("R4 nested insvc", 32'(insvc), 32'h0A);
        do_cmd(4'h2, 0);
        chk("R8 highest only", 32'(insvc), 32'h08);
        chk("R3 type5 blocked", 32'(irq_n), 32'd1);
        do_cmd(4'h2, 0);
        chk("R8 second", 32'(insvc), 32'd0);
        do_ack();
        chk("R5 vector type5", 32'(vec_out), 32'(exp_vec(5)));
        do_cmd(4'h2, 0);

        // R5 ack with no request
        do_ack();
        chk("R5 no request no vector", 32'(vec_valid), 32'd0);

        // R5 vector without status
        set_cfg('1, 1'b1, 1'b0);
        make_pending(2);
        do_ack();
        chk("R5 plain vector", 32'(vec_out), 32'(vec_base));
        do_cmd(4'h2, 0);

        // R6 chain input low
        chain_ein = 1'b0;
        make_pending(4);
        chk("R6 irq_n", 32'(irq_n), 32'd1);
        chk("R6 eout", 32'(chain_eout), 32'd0);
        do_ack();
        chk("R6 no vector", 32'(vec_valid), 32'd0);
        chk("R6 insvc", 32'(insvc), 32'd0);
        chk("R6 pend kept", 32'(pend), 32'h10);
        chain_ein = 1'b1; #1;
        chk("R3 request after ein", 32'(irq_n), 32'd0);

        // R3 R7 master and per-type enable
        set_cfg('1, 1'b0, 1'b1);
        chk("R3 master off", 32'(irq_n), 32'd1);
        chk("R7 eout master off", 32'(chain_eout), 32'd1);
        set_cfg(NT'(~(1 << 4)), 1'b1, 1'b1);
        chk("R3 type disabled", 32'(irq_n), 32'd1);
        chk("R7 eout type disabled", 32'(chain_eout), 32'd1);
        set_cfg('1, 1'b1, 1'b1);
        do_cmd(4'h1, 4);
        chk("R2 clear type4", 32'(pend), 32'd0);

        // R9 edge meets clear command
        make_pending(2);
        src_stat[2*NS] = 1'b1;
        cmd_we = 1'b1; cmd_code = 4'h1; cmd_type = TW'(2);
        tick();
        cmd_we = 1'b0; src_stat[2*NS] = 1'b0;
        chk("R9 edge beats clear", 32'(pend), 32'h04);
        tick();
        // R9 edge meets acknowledge
        src_stat[2*NS] = 1'b1;
        ack = 1'b1;
        tick();
        ack = 1'b0; src_stat[2*NS] = 1'b0;
        chk("R9 edge beats ack pend", 32'(pend), 32'h04);
        chk("R9 ack served", 32'(insvc), 32'h04);
        do_cmd(4'h2, 0);
        do_cmd(4'h1, 2);
        chk("R9 cleanup", 32'(pend | insvc), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule